// File: doc/BRIEF.md
# Receive Character Queue with Level Interrupt

This block holds characters delivered by a serial receiver, or by a transmit loopback path, until software reads them through the data register. Each entry is 12 bits wide. Bits 7:0 carry the character, bit 8 marks a framing error, bit 9 a parity error, bit 10 a received break and bit 11 an overrun. The block stores all twelve bits unchanged. It can run as a 16-entry queue or as a single holding register. The choice follows a queue-enable input that is driven from the line-control register.

The block drives empty, full and can-accept flags, and a level interrupt request for receive data. In queue mode a programmable level-select field sets the trigger occupancy, computed as (level_select >> 1) & 28. In holding-register mode the trigger is always 1. The interrupt is set by the write that brings the occupancy up to the trigger. It is cleared by the read that brings the occupancy down to one below the trigger. Read data is registered and appears in the cycle after a read strobe.

Top module: `rx_char_queue`

## Requirements
- R1: After reset, empty is 1, and full, rx_irq and rd_data are all 0. The block starts in holding-register mode.
- R2: can_accept is 1 exactly when the occupancy is below the effective depth. The effective depth is DEPTH in queue mode (fifo_en = 1) and 1 in holding-register mode (fifo_en = 0).
- R3: In any cycle where fifo_en differs from the current mode, the block takes the new mode and discards all entries. Empty becomes 1, full and rx_irq become 0, and rd_data holds its previous value. A read or write in that same cycle is dropped.
- R4: The trigger is (lvl_sel >> 1) & 28 in queue mode and 1 in holding-register mode. A write without a read that makes the occupancy equal to the trigger sets rx_irq.
- R5: A read without a write that makes the occupancy equal to the trigger minus one clears rx_irq. No other read changes rx_irq.
- R6: full is 1 exactly when the occupancy equals the effective depth. empty is 1 exactly when the occupancy is zero.
- R7: Entries are read back in write order with all 12 bits intact. This includes the break flag in bit 10.
- R8: A write while can_accept is 0 is dropped and changes no flag or entry.
- R9: Read and write positions wrap modulo DEPTH. Long sequences therefore keep their order across the end of the storage.
- R10: A read while the queue is empty leaves the occupancy at zero and leaves rd_data at the last character read.
- R11: In holding-register mode, one write makes the block full and raises rx_irq, and one read empties it and clears rx_irq.
- R12: A read and a write in the same cycle, at an occupancy strictly between zero and the effective depth, keep the occupancy and rx_irq unchanged. The read returns the oldest entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | Queue-enable bit from line control (1 = DEPTH entries, 0 = single entry) |
| lvl_sel | input | LVL_W | Level-select field that sets the trigger |
| wr_en | input | 1 | Write strobe from the receiver or loopback path |
| wr_data | input | ENTRY_W | Character and error flags to store |
| rd_en | input | 1 | Read strobe from the data register |
| rd_data | output | ENTRY_W | Last character read, registered |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals the effective depth |
| can_accept | output | 1 | A write would be stored |
| rx_irq | output | 1 | Receive level interrupt request |

## Verification
The hardest case to reach is an interrupt edge at each trigger value, including triggers of 0 and above the depth, which must never fire. The bench reaches every edge by sweeping all 64 level-select codes, filling the queue one write past full and then draining it one read past empty. Mode flushes are done with entries still stored and the interrupt raised, so the discard shows at the ports. Interleaved and simultaneous read/write runs carry the positions across the end of the storage many times.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int RXQ_ENTRY_W   = 12;
    localparam int RXQ_LVL_W     = 6;
    localparam int RXQ_TRIG_MASK = 28;
endpackage

// File: rtl/rxq_trigger.sv
module rxq_trigger #(
    parameter int LVL_W = rxq_pkg::RXQ_LVL_W
) (
    input  logic             fifo_mode,
    input  logic [LVL_W-1:0] lvl_sel,
    output logic [LVL_W-1:0] trig
);
    logic [LVL_W-1:0] half_sel;

    always_comb begin
        half_sel = lvl_sel >> 1;
        if (fifo_mode) begin
            trig = half_sel & LVL_W'(rxq_pkg::RXQ_TRIG_MASK);
        end else begin
            trig = LVL_W'(1);
        end
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = rxq_pkg::RXQ_ENTRY_W,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue #(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = rxq_pkg::RXQ_ENTRY_W,
    parameter int LVL_W   = rxq_pkg::RXQ_LVL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_en,
    input  logic [LVL_W-1:0]   lvl_sel,
    input  logic               wr_en,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic               rd_en,
    output logic [ENTRY_W-1:0] rd_data,
    output logic               empty,
    output logic               full,
    output logic               can_accept,
    output logic               rx_irq
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic               mode;
        logic [PTR_W-1:0]   wp;
        logic [PTR_W-1:0]   rp;
        logic [CNT_W-1:0]   cnt;
        logic               empty;
        logic               full;
        logic               irq;
        logic [ENTRY_W-1:0] rdat;
    } state_t;

    state_t s_q, s_d;

    logic [LVL_W-1:0]   trig;
    logic [ENTRY_W-1:0] head;
    logic               mode_chg;
    logic               acc_ok;
    logic               push_ok;
    logic               pop_ok;
    logic [CNT_W-1:0]   eff_depth;
    logic [PTR_W-1:0]   ptr_mask;
    logic [CNT_W-1:0]   cnt_n;

    rxq_trigger #(.LVL_W(LVL_W)) i_trig (
        .fifo_mode (s_q.mode),
        .lvl_sel   (lvl_sel),
        .trig      (trig)
    );

    rxq_store #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) i_store (
        .clk   (clk),
        .we    (push_ok),
        .waddr (s_q.wp),
        .wdata (wr_data),
        .raddr (s_q.rp),
        .rdata (head)
    );

    always_comb begin
        s_d       = s_q;
        mode_chg  = (fifo_en != s_q.mode);
        eff_depth = s_q.mode ? CNT_W'(DEPTH) : CNT_W'(1);
        ptr_mask  = s_q.mode ? PTR_W'(DEPTH - 1) : '0;
        acc_ok    = (s_q.cnt < eff_depth);
        push_ok   = wr_en && acc_ok && !mode_chg;
        pop_ok    = rd_en && (s_q.cnt != '0) && !mode_chg;
        cnt_n     = s_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);

        if (mode_chg) begin
            s_d.mode  = fifo_en;
            s_d.wp    = '0;
            s_d.rp    = '0;
            s_d.cnt   = '0;
            s_d.empty = 1'b1;
            s_d.full  = 1'b0;
            s_d.irq   = 1'b0;
        end else begin
            if (push_ok) begin
                s_d.wp = (s_q.wp + PTR_W'(1)) & ptr_mask;
            end
            if (pop_ok) begin
                s_d.rp   = (s_q.rp + PTR_W'(1)) & ptr_mask;
                s_d.rdat = head;
            end
            if (push_ok && !pop_ok && (32'(cnt_n) == 32'(trig))) begin
                s_d.irq = 1'b1;
            end
            if (pop_ok && !push_ok && (32'(cnt_n) + 1 == 32'(trig))) begin
                s_d.irq = 1'b0;
            end
            s_d.cnt   = cnt_n;
            s_d.empty = (cnt_n == '0);
            s_d.full  = (cnt_n == eff_depth);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.empty <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data    = s_q.rdat;
    assign empty      = s_q.empty;
    assign full       = s_q.full;
    assign rx_irq     = s_q.irq;
    assign can_accept = acc_ok;
endmodule

// File: rtl/rx_char_queue_chk.sv
module rx_char_queue_chk #(
    parameter int ENTRY_W = rxq_pkg::RXQ_ENTRY_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fifo_en,
    input logic               mode_q,
    input logic               wr_en,
    input logic               rd_en,
    input logic [ENTRY_W-1:0] rd_data,
    input logic               empty,
    input logic               full,
    input logic               can_accept,
    input logic               rx_irq
);
    // R6
    no_full_and_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R2
    accept_vs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en == mode_q) |-> (can_accept == !full));

    // R3
    flush_on_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != mode_q) |=> (empty && !full && !rx_irq));

    // R10
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en) |=> ($stable(rd_data) && empty));

    // R4
    irq_rise_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(wr_en));

    // R5
    irq_fall_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_irq) |-> ($past(rd_en) || $past(fifo_en != mode_q)));

    // R11
    single_entry_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && (fifo_en == mode_q) && !empty) |-> full);
endmodule

bind rx_char_queue rx_char_queue_chk #(.ENTRY_W(ENTRY_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .mode_q     (s_q.mode),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .empty      (empty),
    .full       (full),
    .can_accept (can_accept),
    .rx_irq     (rx_irq)
);

// File: tb/test_rx_char_queue.sv
`timescale 1ns/1ps
module test_rx_char_queue;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0;
    logic [5:0]  lvl_sel = '0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_data;
    logic        empty, full, can_accept, rx_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int          m_cnt = 0;
    bit          m_irq = 1'b0;
    bit          m_mode = 1'b0;
    logic [11:0] m_q[$];
    logic [11:0] m_last = '0;

    always #2.5 clk = ~clk;

    rx_char_queue i_rx_char_queue (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .lvl_sel(lvl_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty), .full(full), .can_accept(can_accept), .rx_irq(rx_irq)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(string req);
        int depth = m_mode ? DEPTH : 1;
        chk(empty == (m_cnt == 0), {req, "/R6 empty"}, 32'(empty), 32'(m_cnt == 0));
        chk(full == (m_cnt == depth), {req, "/R6 full"}, 32'(full), 32'(m_cnt == depth));
        chk(can_accept == (m_cnt < depth), {req, "/R2 can_accept"}, 32'(can_accept), 32'(m_cnt < depth));
        chk(rx_irq == m_irq, {req, "/R4 R5 rx_irq"}, 32'(rx_irq), 32'(m_irq));
        chk(rd_data == m_last, {req, "/R7 R10 rd_data"}, 32'(rd_data), 32'(m_last));
    endtask

    task automatic step(bit w, bit r, logic [11:0] d, string req);
        int depth = m_mode ? DEPTH : 1;
        int trig = m_mode ? ((int'(lvl_sel) >> 1) & 28) : 1;
        bit pu, po;
        @(negedge clk);
        wr_en = w; rd_en = r; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0;
        pu = w && (m_cnt < depth);
        po = r && (m_cnt > 0);
        if (po) m_last = m_q.pop_front();
        if (pu) m_q.push_back(d);
        m_cnt = m_cnt + int'(pu) - int'(po);
        if (pu && !po && m_cnt == trig) m_irq = 1'b1;
        if (po && !pu && m_cnt == trig - 1) m_irq = 1'b0;
        check_all(req);
    endtask

    task automatic set_mode(bit m);
        @(negedge clk);
        fifo_en = m;
        @(posedge clk);
        #1;
        if (m != m_mode) begin
            m_q.delete();
            m_cnt = 0;
            m_irq = 1'b0;
            m_mode = m;
        end
        check_all("R3 flush");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check_all("R1");

        // R11 holding-register mode, R8 rejected write, R10 empty read
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 1'b0, 12'h0A0 + 12'(k), "R11 push");
            step(1'b1, 1'b0, 12'hF00, "R8 drop");
            step(1'b0, 1'b1, '0, "R11 pop");
            step(1'b0, 1'b1, '0, "R10 empty pop");
        end

        // R3 flush with data and interrupt pending
        step(1'b1, 1'b0, 12'h455, "R11 push");
        set_mode(1'b1);
        step(1'b0, 1'b1, '0, "R3 nothing left");

        // R4 R5 R6 R8 R9 sweep over every level code
        for (int lv = 0; lv < 64; lv++) begin
            @(negedge clk);
            lvl_sel = 6'(lv);
            for (int i = 0; i <= DEPTH; i++) begin
                logic [11:0] d = 12'((i * 37 + lv * 11) & 12'hFFF);
                if (i % 5 == 0) d[10] = 1'b1;
                step(1'b1, 1'b0, d, "R4 fill");
            end
            for (int i = 0; i <= DEPTH; i++) begin
                step(1'b0, 1'b1, '0, "R5 drain");
            end
        end

        // R9 R12 interleaved and simultaneous traffic, trigger 4
        @(negedge clk);
        lvl_sel = 6'd8;
        for (int k = 0; k < 60; k++) begin
            step(k % 3 != 2, k % 2 == 1, 12'(k * 73), "R9 interleave");
        end
        for (int k = 0; k < 30; k++) begin
            step(1'b1, 1'b1, 12'(k * 19 + 5), "R12 both");
        end

        // R3 flush from queue mode back to single entry, then forward again
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 12'(k + 12'h400), "R7 break");
        set_mode(1'b0);
        step(1'b0, 1'b1, '0, "R3 nothing left");
        step(1'b1, 1'b0, 12'h7C3, "R11 push");
        set_mode(1'b1);
        step(1'b1, 1'b1, 12'h123, "R12 both at empty");
        step(1'b0, 1'b1, '0, "R7 pop");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule